// File: doc/BRIEF.md
# Quadratic Spiking Neuron Step Unit

This block advances a single two-variable spiking neuron by one discrete time step each time `step_en` is pulsed. It keeps a membrane variable V and a recovery variable U, both in signed Q8.8 fixed point scaled in millivolts. The membrane step combines a quadratic term, a linear term, a constant bias, the recovery variable and an input current. The recovery variable relaxes toward a scaled copy of V. When the updated membrane value reaches the firing threshold, the block raises a spike flag. In that same step it loads V with a reset level and raises U by a fixed increment.

Four behaviour parameters can be written at run time through a small write port, so one instance can be switched between firing patterns. These are the recovery rate, the recovery sensitivity, the reset level and the recovery increment. A surrounding scheduler drives a current value together with `step_en`. The result of that step, with its spike flag, appears on the outputs and is marked valid in the following cycle.

Top module: `qspike_neuron`

## Requirements
- R1: A synchronous active-high `rst` loads the parameters with their defaults: rate = 655, sensitivity = 6554 (both Q1.15), reset level = -16640 and increment = 2048 (both Q8.8). It also sets V to the reset level and U to sat((sensitivity × reset level) >>> 15), which is -3329, and clears `out_valid` and `spike`.
- R2: While `prm_wr` is high, `prm_data` is stored in the parameter chosen by `prm_sel`: 0 = rate, 1 = sensitivity, 2 = reset level, 3 = increment. The new value is used from the next clock edge onward, so a step taken in the same cycle as a write still uses the old value.
- R3: A step computes Vn = sat(V + ((V·V·2621) >>> 24) + 5·V + 35840 − U + I). All widths are kept full until the final saturation, and >>> is a flooring arithmetic shift.
- R4: A step computes Un = sat(U + ((rate · (((sensitivity · V) >>> 15) − U)) >>> 15)). It uses the V value from before the step.
- R5: A step fires when Vn ≥ 7680 (30 mV). `spike` is then high in the cycle in which the result is valid. A step that does not fire leaves a stored V below 7680.
- R6: In a firing step, V becomes the reset level. U becomes sat(U + du + increment), where du is the recovery change from R4.
- R7: Every stored result saturates to the range −32768 to 32767 and does not wrap.
- R8: `out_valid` is high exactly in the cycle after each cycle in which `step_en` was sampled high. `spike` is never high without `out_valid`.
- R9: In a cycle without `step_en`, V and U keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prm_wr | input | 1 | Parameter write strobe |
| prm_sel | input | 2 | Parameter select: 0 rate, 1 sensitivity, 2 reset level, 3 increment |
| prm_data | input | 16 | Parameter value |
| step_en | input | 1 | Advance the neuron by one step |
| cur_in | input | 16 | Input current, signed Q8.8 |
| out_valid | output | 1 | Result of the previous cycle's step is present |
| spike | output | 1 | The step shown fired |
| v_out | output | 16 | Membrane variable, signed Q8.8 |
| u_out | output | 16 | Recovery variable, signed Q8.8 |

## Verification
Every step produces its result one clock after `step_en` is sampled: the state registers, the spike flag and `out_valid` all change at that same edge. The driver applies a step on a falling edge and pushes the model's expected V, U and spike into a queue. The monitor pops that queue only on a falling edge where `out_valid` is high, so each comparison lands exactly one cycle after its step. Back-to-back steps therefore line up in order. A parameter write takes effect at the same edge as a concurrent step, and the model applies the write only after computing that step.

// File: rtl/qspike_neuron.sv
module qspike_neuron #(
  parameter int W      = 16,
  parameter int FRAC   = 8,
  parameter int CFRAC  = 15,
  parameter int KQUAD  = 2621,
  parameter int KSH    = 16,
  parameter int THR_MV = 30,
  parameter int BIAS_MV = 140,
  parameter int A_INIT = 655,
  parameter int B_INIT = 6554,
  parameter int C_INIT = -16640,
  parameter int D_INIT = 2048
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                prm_wr,
  input  logic [1:0]          prm_sel,
  input  logic [W-1:0]        prm_data,
  input  logic                step_en,
  input  logic signed [W-1:0] cur_in,
  output logic                out_valid,
  output logic                spike,
  output logic signed [W-1:0] v_out,
  output logic signed [W-1:0] u_out
);

  localparam int XW = 3 * W;
  localparam logic signed [XW-1:0] XMAX = XW'((64'sd1 <<< (W-1)) - 1);
  localparam logic signed [XW-1:0] XMIN = -XMAX - 1;
  localparam logic signed [XW-1:0] KQ   = XW'(KQUAD);
  localparam logic signed [XW-1:0] BIAS = XW'(BIAS_MV <<< FRAC);
  localparam logic signed [W-1:0]  THR  = W'(THR_MV <<< FRAC);
  localparam longint BC_RAW = (longint'(B_INIT) * longint'(C_INIT)) >>> CFRAC;
  localparam longint UMAX = (64'sd1 <<< (W-1)) - 1;
  localparam logic signed [W-1:0] U_RST =
    W'((BC_RAW > UMAX) ? UMAX : (BC_RAW < -UMAX - 1) ? (-UMAX - 1) : BC_RAW);

  function automatic logic signed [W-1:0] clip(input logic signed [XW-1:0] x);
    if (x > XMAX)      clip = XMAX[W-1:0];
    else if (x < XMIN) clip = XMIN[W-1:0];
    else               clip = x[W-1:0];
  endfunction

  logic signed [W-1:0] a_q, b_q, c_q, d_q, v_q, u_q;
  logic                valid_q, spike_q;

  logic signed [XW-1:0] vx, ux, ix, ax, bx, dx;
  logic signed [XW-1:0] vsq, quad, vsum, bv, du;
  logic signed [W-1:0]  v_upd, u_upd, u_bump;
  logic                 fire;

  assign vx = XW'(v_q);
  assign ux = XW'(u_q);
  assign ix = XW'(cur_in);
  assign ax = XW'(a_q);
  assign bx = XW'(b_q);
  assign dx = XW'(d_q);

  assign vsq  = vx * vx;
  assign quad = (vsq * KQ) >>> (FRAC + KSH);
  assign vsum = vx + quad + (vx <<< 2) + vx + BIAS - ux + ix;
  assign v_upd = clip(vsum);

  assign bv = (bx * vx) >>> CFRAC;
  assign du = (ax * (bv - ux)) >>> CFRAC;
  assign u_upd  = clip(ux + du);
  assign u_bump = clip(ux + du + dx);

  assign fire = (v_upd >= THR);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= W'(A_INIT);
      b_q <= W'(B_INIT);
      c_q <= W'(C_INIT);
      d_q <= W'(D_INIT);
    end else if (prm_wr) begin
      case (prm_sel)
        2'd0:    a_q <= prm_data;
        2'd1:    b_q <= prm_data;
        2'd2:    c_q <= prm_data;
        default: d_q <= prm_data;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q     <= W'(C_INIT);
      u_q     <= U_RST;
      valid_q <= 1'b0;
      spike_q <= 1'b0;
    end else begin
      valid_q <= step_en;
      spike_q <= step_en & fire;
      if (step_en) begin
        v_q <= fire ? c_q : v_upd;
        u_q <= fire ? u_bump : u_upd;
      end
    end
  end

  assign out_valid = valid_q;
  assign spike     = spike_q;
  assign v_out     = v_q;
  assign u_out     = u_q;

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
    step_en |=> out_valid);
  p_no_stray_valid_r8: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> !out_valid);
  p_spike_with_valid_r8: assert property (@(posedge clk) disable iff (rst)
    spike |-> out_valid);
  p_hold_state_r9: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> ($stable(v_out) && $stable(u_out)));
  p_below_thr_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !spike) |-> (v_out < THR));
  p_reset_level_r6: assert property (@(posedge clk) disable iff (rst)
    (step_en && !prm_wr) |=> (spike |-> (v_out == $past(c_q))));

endmodule

// File: tb/test_qspike_neuron.sv
module test_qspike_neuron;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prm_wr = 1'b0;
  logic [1:0] prm_sel = 2'd0;
  logic [15:0] prm_data = 16'd0;
  logic step_en = 1'b0;
  logic signed [15:0] cur_in = 16'sd0;
  logic out_valid, spike;
  logic signed [15:0] v_out, u_out;

  qspike_neuron i_qspike_neuron (
    .clk(clk), .rst(rst), .prm_wr(prm_wr), .prm_sel(prm_sel),
    .prm_data(prm_data), .step_en(step_en), .cur_in(cur_in),
    .out_valid(out_valid), .spike(spike), .v_out(v_out), .u_out(u_out)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct { bit sp; longint v; longint u; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  int exp_spikes = 0, obs_spikes = 0;
  longint max_u = -100000;
  longint ma, mb, mc, md, mv, mu;

  function automatic longint sat16(input longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    ma = 655; mb = 6554; mc = -16640; md = 2048;
    mv = mc;
    mu = sat16((mb * mc) >>> 15);
  endtask

  function automatic exp_t model_step(input longint i);
    exp_t e;
    longint vn, du, bv;
    vn = sat16(mv + ((mv * mv * 2621) >>> 24) + 5 * mv + 35840 - mu + i);
    bv = (mb * mv) >>> 15;
    du = (ma * (bv - mu)) >>> 15;
    if (vn >= 7680) begin
      e.sp = 1'b1; e.v = mc; e.u = sat16(mu + du + md);
    end else begin
      e.sp = 1'b0; e.v = vn; e.u = sat16(mu + du);
    end
    return e;
  endfunction

  // one step; optional concurrent parameter write
  task automatic step(input longint i, input bit wr, input int sel, input longint val);
    exp_t e;
    @(negedge clk);
    e = model_step(i);
    mv = e.v; mu = e.u;
    if (e.sp) exp_spikes++;
    q.push_back(e);
    cur_in = 16'(i);
    step_en = 1'b1;
    prm_wr = wr;
    prm_sel = 2'(sel);
    prm_data = 16'(val);
    if (wr) begin
      case (sel)
        0: ma = val; 1: mb = val; 2: mc = val; default: md = val;
      endcase
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      step_en = 1'b0; prm_wr = 1'b0;
    end
  endtask

  task automatic write_prm(input int sel, input longint val);
    @(negedge clk);
    step_en = 1'b0;
    prm_wr = 1'b1; prm_sel = 2'(sel); prm_data = 16'(val);
    case (sel)
      0: ma = val; 1: mb = val; 2: mc = val; default: md = val;
    endcase
    @(negedge clk);
    prm_wr = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R8 unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (spike) obs_spikes++;
        if (longint'(u_out) > max_u) max_u = longint'(u_out);
        check(spike == e.sp, "R5 spike flag", spike, e.sp);
        check(longint'(v_out) == e.v, e.sp ? "R6 V reset" : "R3 V update", v_out, e.v);
        check(longint'(u_out) == e.u, e.sp ? "R6 U bump" : "R4 U update", u_out, e.u);
      end
    end
  end

  initial begin
    #(PERIOD * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint hv, hu;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(longint'(v_out) == mv, "R1 reset V", v_out, mv);
    check(longint'(u_out) == mu, "R1 reset U", u_out, mu);
    check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);

    // R9 and R8 while idle
    idle(5);
    check(longint'(v_out) == mv && longint'(u_out) == mu, "R9 hold V/U", v_out, mv);
    check(out_valid == 1'b0, "R8 no valid when idle", out_valid, 0);

    // regular pattern, I = 10 mV, back-to-back
    for (int k = 0; k < 300; k++) step(2560, 1'b0, 0, 0);
    idle(2);
    check(obs_spikes > 0, "R5 spikes seen", obs_spikes, exp_spikes);

    // gaps between steps, state must hold (R9)
    for (int k = 0; k < 20; k++) begin
      step(1280, 1'b0, 0, 0);
      idle(1);
      hv = mv; hu = mu;
      idle(2);
      check(longint'(v_out) == hv && longint'(u_out) == hu, "R9 hold after step", v_out, hv);
    end

    // R2 writes: new reset level and increment, then rate written during a step
    write_prm(2, -12800);
    write_prm(3, 512);
    step(2560, 1'b1, 0, 3277);
    for (int k = 0; k < 150; k++) step(2560, 1'b0, 0, 0);
    idle(2);

    // R2 sensitivity change, quiet input
    write_prm(1, 8192);
    for (int k = 0; k < 60; k++) step(0, 1'b0, 0, 0);
    idle(2);

    // R7 saturation: high reset level, large increment, strong drive
    write_prm(2, 5120);
    write_prm(3, 25600);
    write_prm(0, 0);
    for (int k = 0; k < 40; k++) step(32767, 1'b0, 0, 0);
    idle(2);
    check(max_u == 32767, "R7 U saturates high", max_u, 32767);

    // strong negative drive
    write_prm(0, 655);
    write_prm(2, -16640);
    for (int k = 0; k < 40; k++) step(-32768, 1'b0, 0, 0);
    idle(3);

    check(q.size() == 0, "R8 every step produced a result", q.size(), 0);
    check(obs_spikes == exp_spikes, "R5 spike count", obs_spikes, exp_spikes);

    // R1 reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    model_reset();
    check(longint'(v_out) == mv && longint'(u_out) == mu && !out_valid, "R1 re-reset", v_out, mv);
    step(2560, 1'b0, 0, 0);
    idle(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule